// File: doc/BRIEF.md
# Receive Buffer Descriptor Manager

This block serves an Ethernet receive DMA. It walks a ring of two-word buffer descriptors held in system memory. When the first word of a frame is offered, the block reads word 0 of the current descriptor and checks its ownership flag. If software still owns the buffer, the frame is discarded and a resource error is reported. Otherwise the block forms the buffer address and writes the frame's 32-bit words into the buffer, one after another.

Frames longer than one buffer chain into the following descriptors. Each descriptor the block consumes is written back in two steps. Word 1 is written first and carries the byte count and the first/last-buffer flags. Word 0 is then rewritten with its ownership flag set. An optional packet-buffer mode lets each of the four upper address bits come from a register value in place of the descriptor. The mode and override values are sampled only when a frame begins.

All memory traffic goes through one request/acknowledge port. Both descriptor reads and data/descriptor writes use it.

Top module: `rx_desc_mgr`

## Requirements
- R1: After reset, `mem_req`, `rx_ready`, `bna_pulse` and `frm_done` are low and `rsrc_err_cnt` is zero.
- R2: When `rx_vld` and `rx_sof` are seen in the idle state, the block first reads word 0 at `ring_base + 8*index`. `rx_ready` stays low until that read has returned.
- R3: If bit 0 (owned) of the fetched word 0 is 1, the block writes no data. It pulses `bna_pulse` for one cycle, increments `rsrc_err_cnt`, and holds `rx_ready` high until the word carrying `rx_eof` has been taken and dropped.
- R4: A descriptor found owned does not advance the index. The next frame fetches the same location again.
- R5: Data word k of a buffer is written to the buffer address + 4*k. The buffer address is word 0 with bits [1:0] cleared.
- R6: While `pb_mode` is 1, address bit 28+b is `ovr_val[b]` when `ovr_en[b]` is 1, for b = 0..3. With `pb_mode` at 0 all address bits come from the descriptor.
- R7: `pb_mode`, `ovr_en` and `ovr_val` are sampled when a frame's first word is offered in the idle state. Changes during the frame have no effect on that frame.
- R8: A buffer holds `buf_units*BUF_UNIT_B` bytes (`buf_units` nonzero). When it fills before `rx_eof`, the descriptor is written back and the next one is fetched and checked as in R3.
- R9: Each consumed descriptor is written back in this order. Word 1 goes first: bits [LEN_W-1:0] hold the frame bytes written so far, bit 30 is set in the frame's first descriptor, bit 31 is set in its last, and all other bits are 0. Word 0 follows, as read but with bit 0 set.
- R10: Word 0 bit 1 (wrap) set makes the next index 0. Otherwise the index increments.
- R11: `frm_done` pulses for one cycle after the last descriptor of a completed frame is written back. A dropped frame gives no pulse.
- R12: `rsrc_err_cnt` saturates at its all-ones value.
- R13: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of descriptor 0 |
| buf_units | input | 8 | Buffer size in units of BUF_UNIT_B bytes |
| pb_mode | input | 1 | Packet-buffer mode, enables upper-address override |
| ovr_en | input | 4 | Per-bit override enable for address bits 31:28 |
| ovr_val | input | 4 | Override values for address bits 31:28 |
| rx_vld | input | 1 | Receive word valid |
| rx_sof | input | 1 | Word is the first of its frame |
| rx_eof | input | 1 | Word is the last of its frame |
| rx_data | input | 32 | Receive word |
| rx_ready | output | 1 | Receive word taken this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | 32 | Memory read data |
| bna_pulse | output | 1 | Buffer-not-available event |
| frm_done | output | 1 | Frame fully stored and written back |
| rsrc_err_cnt | output | CNT_W | Saturating resource-error count |

## Verification
The bench builds the block with `BUF_UNIT_B = 16`, `buf_units = 1`, `CNT_W = 2` and `IDX_W = 3`. Buffers are therefore four words long, so a frame of only a few words already exercises single-buffer frames, exact fills, frames spread over three descriptors, and the wrap of a four-entry ring. The 2-bit counter reaches saturation after three owned-descriptor hits. The bench also places an owned descriptor in the middle of a frame, which drops the tail of the frame after the first buffer has been written back.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_WB1,
        ST_WB0,
        ST_DROP
    } mgr_st_e;

    localparam int OVR_W    = 4;
    localparam int USED_POS = 0;
    localparam int WRAP_POS = 1;
    localparam int SOF_POS  = 30;
    localparam int EOF_POS  = 31;
    localparam int DESC_LG  = 3;
    localparam int WORD_B   = 4;

endpackage

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr
    import rxbd_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        wrap,
    input  logic [31:0] ring_base,
    output logic [31:0] desc_addr
);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (adv) begin
            idx_d = wrap ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign desc_addr = ring_base + (32'(idx_q) << DESC_LG);

endmodule

// File: rtl/rxbd_addr_mux.sv
module rxbd_addr_mux
    import rxbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch,
    input  logic             mode_in,
    input  logic [OVR_W-1:0] en_in,
    input  logic [OVR_W-1:0] val_in,
    input  logic [29:0]      desc_ptr,
    output logic [31:0]      buf_addr
);

    typedef struct packed {
        logic             mode;
        logic [OVR_W-1:0] en;
        logic [OVR_W-1:0] val;
    } ovr_t;

    ovr_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (latch) begin
            act_d.mode = mode_in;
            act_d.en   = en_in;
            act_d.val  = val_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign buf_addr[1:0]          = 2'b00;
    assign buf_addr[31-OVR_W:2]   = desc_ptr[29-OVR_W:0];

    for (genvar b = 0; b < OVR_W; b++) begin : g_ovr
        assign buf_addr[32-OVR_W+b] = (act_q.mode && act_q.en[b]) ? act_q.val[b]
                                                                 : desc_ptr[30-OVR_W+b];
    end

endmodule

// File: rtl/rxbd_sat_cnt.sv
module rxbd_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rx_desc_mgr.sv
module rx_desc_mgr
    import rxbd_pkg::*;
#(
    parameter int IDX_W      = 10,
    parameter int BUF_UNIT_B = 64,
    parameter int CNT_W      = 16,
    parameter int LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      ring_base,
    input  logic [7:0]       buf_units,
    input  logic             pb_mode,
    input  logic [3:0]       ovr_en,
    input  logic [3:0]       ovr_val,
    input  logic             rx_vld,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [31:0]      rx_data,
    output logic             rx_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             bna_pulse,
    output logic             frm_done,
    output logic [CNT_W-1:0] rsrc_err_cnt
);

    localparam int UNIT_LG = $clog2(BUF_UNIT_B);
    localparam int OFF_W   = 8 + UNIT_LG;

    typedef struct packed {
        mgr_st_e          st;
        logic [31:0]      word0;
        logic [OFF_W-1:0] off;
        logic [LEN_W-1:0] flen;
        logic             sof;
        logic             eof;
        logic             bna;
        logic             done;
    } mgr_regs_t;

    localparam mgr_regs_t REGS_RST = '{
        st: ST_IDLE, word0: '0, off: '0, flen: '0,
        sof: 1'b0, eof: 1'b0, bna: 1'b0, done: 1'b0
    };

    mgr_regs_t        r_d, r_q;
    logic             adv_ptr;
    logic             latch_ovr;
    logic [31:0]      desc_addr;
    logic [31:0]      buf_addr;
    logic [OFF_W-1:0] buf_bytes;
    logic [OFF_W-1:0] off_nxt;

    assign buf_bytes = {buf_units, {UNIT_LG{1'b0}}};
    assign off_nxt   = r_q.off + OFF_W'(WORD_B);

    rxbd_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv_ptr),
        .wrap      (r_q.word0[WRAP_POS]),
        .ring_base (ring_base),
        .desc_addr (desc_addr)
    );

    rxbd_addr_mux u_amux (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch    (latch_ovr),
        .mode_in  (pb_mode),
        .en_in    (ovr_en),
        .val_in   (ovr_val),
        .desc_ptr (r_q.word0[31:2]),
        .buf_addr (buf_addr)
    );

    rxbd_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (r_q.bna),
        .cnt   (rsrc_err_cnt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.bna   = 1'b0;
        r_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        adv_ptr   = 1'b0;
        latch_ovr = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (rx_vld && rx_sof) begin
                    latch_ovr = 1'b1;
                    r_d.st    = ST_FETCH;
                    r_d.sof   = 1'b1;
                    r_d.eof   = 1'b0;
                    r_d.flen  = '0;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
                if (mem_ack) begin
                    r_d.word0 = mem_rdata;
                    r_d.off   = '0;
                    if (mem_rdata[USED_POS]) begin
                        r_d.bna = 1'b1;
                        r_d.st  = ST_DROP;
                    end else begin
                        r_d.st  = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                mem_req   = rx_vld;
                mem_we    = 1'b1;
                mem_addr  = buf_addr + 32'(r_q.off);
                mem_wdata = rx_data;
                rx_ready  = mem_ack;
                if (mem_ack) begin
                    r_d.off  = off_nxt;
                    r_d.flen = r_q.flen + LEN_W'(WORD_B);
                    if (rx_eof) begin
                        r_d.eof = 1'b1;
                        r_d.st  = ST_WB1;
                    end else if (off_nxt == buf_bytes) begin
                        r_d.st  = ST_WB1;
                    end
                end
            end
            ST_WB1: begin
                mem_req                 = 1'b1;
                mem_we                  = 1'b1;
                mem_addr                = desc_addr + 32'(WORD_B);
                mem_wdata[LEN_W-1:0]    = r_q.flen;
                mem_wdata[SOF_POS]      = r_q.sof;
                mem_wdata[EOF_POS]      = r_q.eof;
                if (mem_ack) r_d.st = ST_WB0;
            end
            ST_WB0: begin
                mem_req             = 1'b1;
                mem_we              = 1'b1;
                mem_addr            = desc_addr;
                mem_wdata           = r_q.word0;
                mem_wdata[USED_POS] = 1'b1;
                if (mem_ack) begin
                    adv_ptr = 1'b1;
                    r_d.sof = 1'b0;
                    if (r_q.eof) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st   = ST_FETCH;
                    end
                end
            end
            ST_DROP: begin
                rx_ready = 1'b1;
                if (rx_vld && rx_eof) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign bna_pulse = r_q.bna;
    assign frm_done  = r_q.done;

endmodule

// File: rtl/rxbd_chk.sv
module rxbd_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic [31:0]      mem_rdata,
    input logic             rx_ready,
    input logic             bna_pulse,
    input logic             frm_done,
    input logic [CNT_W-1:0] rsrc_err_cnt
);

    // R3
    owned_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && !mem_we && mem_rdata[0]) |=> bna_pulse);

    // R3
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bna_pulse |-> (!mem_req && rx_ready));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bna_pulse && (rsrc_err_cnt != {CNT_W{1'b1}})) |=> (rsrc_err_cnt == $past(rsrc_err_cnt) + 1'b1));

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bna_pulse |=> $stable(rsrc_err_cnt));

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bna_pulse, frm_done}));

endmodule

bind rx_desc_mgr rxbd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .rx_ready     (rx_ready),
    .bna_pulse    (bna_pulse),
    .frm_done     (frm_done),
    .rsrc_err_cnt (rsrc_err_cnt)
);

// File: tb/tb_rx_desc_mgr.sv
module tb_rx_desc_mgr;

    localparam int CNT_W   = 2;
    localparam int BUF_B   = 16;
    localparam logic [31:0] RING = 32'h0000_0100;
    localparam int NVEC    = 8;
    // fields: [17:12] words, [11] mode, [10:7] en, [6:3] val, [2:1] owned slot, [0] mid-frame change
    localparam logic [17:0] VEC [NVEC] = '{
        {6'd3, 1'b0, 4'h0, 4'h0, 2'd0, 1'b0},
        {6'd4, 1'b1, 4'h0, 4'hF, 2'd0, 1'b0},
        {6'd6, 1'b1, 4'hA, 4'hF, 2'd0, 1'b0},
        {6'd2, 1'b0, 4'h0, 4'h0, 2'd0, 1'b1},
        {6'd3, 1'b0, 4'h0, 4'h0, 2'd1, 1'b0},
        {6'd9, 1'b1, 4'h1, 4'h0, 2'd0, 1'b0},
        {6'd6, 1'b0, 4'h0, 4'h0, 2'd2, 1'b0},
        {6'd1, 1'b0, 4'h0, 4'h0, 2'd0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      ring_base = RING;
    logic [7:0]       buf_units = 8'd1;
    logic             pb_mode = 1'b0;
    logic [3:0]       ovr_en = '0;
    logic [3:0]       ovr_val = '0;
    logic             rx_vld = 1'b0;
    logic             rx_sof = 1'b0;
    logic             rx_eof = 1'b0;
    logic [31:0]      rx_data = '0;
    logic             rx_ready;
    logic             mem_req, mem_we, mem_ack;
    logic [31:0]      mem_addr, mem_wdata, mem_rdata;
    logic             bna_pulse, frm_done;
    logic [CNT_W-1:0] rsrc_err_cnt;

    always #5 clk = ~clk;

    rx_desc_mgr #(.IDX_W(3), .BUF_UNIT_B(16), .CNT_W(CNT_W), .LEN_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .buf_units(buf_units),
        .pb_mode(pb_mode), .ovr_en(ovr_en), .ovr_val(ovr_val),
        .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .bna_pulse(bna_pulse), .frm_done(frm_done), .rsrc_err_cnt(rsrc_err_cnt)
    );

    int errs = 0;
    int checks = 0;

    // memory model and transaction log
    logic [31:0] mem [logic [31:0]];
    logic        log_we   [64];
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_n = 0;
    int          bna_seen = 0;
    int          done_seen = 0;
    int          viol = 0;
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wdata = '0;

    initial mem_ack = 1'b0;
    initial mem_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (log_n < 64) begin
                log_we[log_n]   = mem_we;
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_n = log_n + 1;
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (bna_pulse) bna_seen = bna_seen + 1;
            if (frm_done)  done_seen = done_seen + 1;
            if (p_req && !p_ack &&
                (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wdata))
                viol = viol + 1;
        end
        p_req   <= mem_req;
        p_ack   <= mem_ack;
        p_we    <= mem_we;
        p_addr  <= mem_addr;
        p_wdata <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench-side view of the ring
    int          b_idx = 0;
    bit          b_used [4];
    int          e_cnt = 0;
    logic        exp_we   [64];
    logic [31:0] exp_addr [64];
    logic [31:0] exp_data [64];
    string       exp_tag  [64];
    int          ne, e_bna, e_done;

    function automatic logic [31:0] daddr(int d);
        return RING + 32'(d * 8);
    endfunction

    function automatic logic [31:0] bbase(int d);
        return 32'h1000_0000 + 32'(d * 256);
    endfunction

    function automatic logic [31:0] w0_of(int d, bit owned);
        logic [31:0] w = bbase(d);
        w[1] = (d == 3);
        w[0] = owned;
        return w;
    endfunction

    function automatic logic [31:0] form(logic [31:0] b, bit md, logic [3:0] en, logic [3:0] v);
        logic [31:0] r = b;
        if (md) for (int i = 0; i < 4; i++) if (en[i]) r[28+i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] dword(int fid, int w);
        return {8'(fid), 24'(w)};
    endfunction

    task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d, input string t);
        exp_we[ne] = we; exp_addr[ne] = a; exp_data[ne] = d; exp_tag[ne] = t;
        ne++;
    endtask

    task automatic model_frame(input int n, input bit md, input logic [3:0] en,
                               input logic [3:0] v, input int fid);
        int w = 0;
        bit sof = 1'b1;
        bit eof;
        int d, off;
        logic [31:0] ba;
        ne = 0; e_bna = 0; e_done = 0;
        forever begin
            d = b_idx;
            push(1'b0, daddr(d), 32'h0, "R2 R4 R10 fetch");
            if (b_used[d]) begin
                e_bna = 1;
                break;
            end
            ba  = form(bbase(d), md, en, v);
            off = 0;
            while (w < n && off < BUF_B) begin
                push(1'b1, ba + 32'(off), dword(fid, w), "R5 R6 R7 R8 data");
                w++;
                off += 4;
            end
            eof = (w == n);
            push(1'b1, daddr(d) + 32'd4, {eof, sof, 14'b0, 16'(w * 4)}, "R9 word1");
            push(1'b1, daddr(d), w0_of(d, 1'b1), "R9 word0");
            b_used[d] = 1'b1;
            b_idx = (d == 3) ? 0 : d + 1;
            sof = 1'b0;
            if (eof) begin
                e_done = 1;
                break;
            end
        end
        if (e_bna != 0 && e_cnt < 3) e_cnt++;
    endtask

    task automatic send_frame(input int n, input bit midchg, input int fid);
        for (int k = 0; k < n; k++) begin
            rx_vld  = 1'b1;
            rx_sof  = (k == 0);
            rx_eof  = (k == n - 1);
            rx_data = dword(fid, k);
            do @(negedge clk); while (!rx_ready);
            @(posedge clk);
            #1;
            if (midchg && k == 0) begin
                pb_mode = 1'b1;
                ovr_en  = 4'hF;
                ovr_val = 4'hF;
            end
        end
        rx_vld = 1'b0;
        rx_sof = 1'b0;
        rx_eof = 1'b0;
    endtask

    task automatic run_vec(input int n, input bit md, input logic [3:0] en, input logic [3:0] v,
                           input int hold, input bit midchg, input int fid);
        for (int d = 0; d < 4; d++) begin
            mem[daddr(d)] = w0_of(d, 1'b0);
            b_used[d] = 1'b0;
        end
        if (hold != 0) begin
            mem[daddr((b_idx + hold - 1) % 4)] = w0_of((b_idx + hold - 1) % 4, 1'b1);
            b_used[(b_idx + hold - 1) % 4] = 1'b1;
        end
        pb_mode = md; ovr_en = en; ovr_val = v;
        model_frame(n, md, en, v, fid);
        log_n = 0; bna_seen = 0; done_seen = 0;
        send_frame(n, midchg, fid);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(log_n == ne, "R2 R8 R9 transaction count", 64'(log_n), 64'(ne));
        for (int i = 0; i < ne && i < log_n; i++) begin
            chk(log_we[i] == exp_we[i] && log_addr[i] == exp_addr[i] &&
                (!exp_we[i] || log_data[i] == exp_data[i]), exp_tag[i],
                {log_addr[i], log_data[i]}, {exp_addr[i], exp_data[i]});
        end
        chk(bna_seen == e_bna, "R3 owned pulse count", 64'(bna_seen), 64'(e_bna));
        chk(done_seen == e_done, "R11 done pulse count", 64'(done_seen), 64'(e_done));
        chk(rsrc_err_cnt == CNT_W'(e_cnt), "R3 R12 error count", 64'(rsrc_err_cnt), 64'(e_cnt));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R13 watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 64'd0);
        chk(rx_ready == 1'b0, "R1 rx_ready", 64'(rx_ready), 64'd0);
        chk(bna_pulse == 1'b0 && frm_done == 1'b0, "R1 pulses",
            64'({bna_pulse, frm_done}), 64'd0);
        chk(rsrc_err_cnt == '0, "R1 counter", 64'(rsrc_err_cnt), 64'd0);
        @(posedge clk);
        #1;

        for (int i = 0; i < NVEC; i++) begin
            run_vec(int'(VEC[i][17:12]), VEC[i][11], VEC[i][10:7], VEC[i][6:3],
                    int'(VEC[i][2:1]), VEC[i][0], i + 1);
        end

        // R12 saturation: two more owned hits take the 2-bit counter to 3 and keep it there
        run_vec(2, 1'b0, 4'h0, 4'h0, 1, 1'b0, 20);
        run_vec(2, 1'b0, 4'h0, 4'h0, 1, 1'b0, 21);

        // R13 request stability seen at the memory port
        chk(viol == 0, "R13 request held until ack", 64'(viol), 64'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule